// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block decides, once per clock, whether the processor core enters a trap handler, and which kind of entry it takes. Four request sources compete: an address-translation fault (protection or miss, tagged with the access kind), a hardware exception raised by the pipeline, a hardware break and an external interrupt. From the current program counter, the status word, the delay-slot and immediate-prefix flags, the pending branch target and a vector base, it works out the handler address and the link register to write with its return address. It also produces the updated status word, the exception cause, the faulting address and the saved branch target.

All results are registered. A one-cycle `entry_valid_o` pulse marks the cycle in which the new program counter and every write enable apply. The same pulse also tells the core to drop its load-reserved address and clear its instruction-state flags. The register file, the translation lookup and instruction decode stay outside the block, and the block only sees them through its ports.

Top module: `exc_entry_ctrl`

## Requirements
- R1: The new PC equals the vector base plus 0x10 for an interrupt entry, plus 0x18 for a break entry, and plus 0x20 for both a hardware-exception entry and a translation-fault entry.
- R2: An interrupt entry writes the current PC to link register 14. A break entry writes the current PC to link register 16. A hardware-exception entry writes PC+4 to link register 17.
- R3: A translation-fault entry writes link register 17. The value is PC−8 when the fault sits in a delay slot whose branch used an immediate prefix, PC−4 in any other delay slot, PC−4 after an immediate prefix, and PC otherwise.
- R4: The cause code of a translation fault is 16 for a data protection fault, 17 for a fetch protection fault, 18 for a data miss and 19 for a fetch miss. Bit 10 is added for a store. The access kind is encoded as 0 = load, 1 = store, 2 = fetch.
- R5: On a hardware-exception or translation-fault entry, cause bit 12 is set and the branch-target register is written with the pending target when the faulting instruction is in a delay slot. Otherwise bit 12 is cleared and the branch-target register is not written. A hardware-exception cause is taken from its input, with bit 12 replaced in this way.
- R6: On every entry the status word has user mode (bit 11) copied to bit 12 and virtual mode (bit 13) copied to bit 14, and then bits 11 and 13 are cleared. An interrupt entry also clears interrupt-enable (bit 1). A break entry sets break-in-progress (bit 3). Exception and fault entries set exception-in-progress (bit 9).
- R7: An interrupt is taken only when bit 1 is set, bits 3 and 9 are clear, and neither the delay-slot flag nor the immediate-prefix flag is set.
- R8: When several requests are pending together, exactly one entry is taken. The order is translation fault, then hardware exception, then break, then interrupt.
- R9: A hardware-exception request made while exceptions are disabled by configuration causes no entry and no write. It does not block a lower-priority request.
- R10: The fault-address output is written with the fault address on every translation-fault entry, and on a hardware-exception entry when that request marks an address fault. It is never written on interrupt or break entries.
- R11: `entry_valid_o`, the reservation clear and the instruction-flag clear pulse for one cycle, in the cycle after the request is sampled. They are low when no request is accepted.
- R12: During reset every pulse and write enable output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_exc_en_i | input | 1 | Configuration: hardware exceptions enabled |
| vec_base_i | input | 32 | Vector base address |
| pc_i | input | 32 | Current program counter |
| msr_i | input | 32 | Current status word |
| dslot_i | input | 1 | Current instruction is in a delay slot |
| imm_i | input | 1 | Current instruction follows an immediate prefix |
| bimm_i | input | 1 | Branch owning the delay slot used an immediate prefix |
| btarget_i | input | 32 | Pending branch target |
| fault_addr_i | input | 32 | Faulting data or fetch address |
| hw_exc_req_i | input | 1 | Hardware exception request |
| hw_exc_cause_i | input | 32 | Hardware exception cause word |
| hw_exc_ear_i | input | 1 | Hardware exception carries a fault address |
| mmu_req_i | input | 1 | Translation fault request |
| mmu_miss_i | input | 1 | Fault kind: 1 miss, 0 protection |
| mmu_acc_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| brk_req_i | input | 1 | Hardware break request |
| irq_req_i | input | 1 | External interrupt request |
| entry_valid_o | output | 1 | Entry taken this cycle |
| pc_o | output | 32 | Handler address |
| link_we_o | output | 1 | Link register write enable |
| link_idx_o | output | 5 | Link register index |
| link_val_o | output | 32 | Return address |
| msr_o | output | 32 | Updated status word |
| esr_we_o | output | 1 | Cause register write enable |
| esr_o | output | 32 | Cause value |
| ear_we_o | output | 1 | Fault address register write enable |
| ear_o | output | 32 | Fault address value |
| btr_we_o | output | 1 | Branch-target register write enable |
| btr_o | output | 32 | Saved branch target |
| resv_clr_o | output | 1 | Invalidate load-reserved address |
| iflags_clr_o | output | 1 | Clear instruction-state flags |

## Verification
A translation fault and a hardware exception can both be pending in one cycle, and so can a break and an interrupt. The bench raises them together, along with all four requests at once. It judges the result from the link index, the return address and the cause code, which differ between the competing kinds. For example, a lone fault gives return address PC where an exception gives PC+4. A disabled-exception request is also paired with a break, to show that the ignored request leaves the break to be taken.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  typedef enum logic [2:0] {
    KIND_NONE = 3'd0,
    KIND_MMU  = 3'd1,
    KIND_HWE  = 3'd2,
    KIND_BRK  = 3'd3,
    KIND_IRQ  = 3'd4
  } entry_kind_e;

  localparam logic [1:0] ACC_LOAD  = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam logic [4:0] LINK_IRQ = 5'd14;
  localparam logic [4:0] LINK_BRK = 5'd16;
  localparam logic [4:0] LINK_EXC = 5'd17;

  localparam int unsigned OFF_IRQ = 'h10;
  localparam int unsigned OFF_BRK = 'h18;
  localparam int unsigned OFF_EXC = 'h20;
endpackage

// File: rtl/exc_entry_arb.sv
module exc_entry_arb
  import exc_entry_pkg::*;
(
  input  logic        mmu_req_i,
  input  logic        hw_req_i,
  input  logic        cfg_exc_en_i,
  input  logic        brk_req_i,
  input  logic        irq_req_i,
  input  logic        ie_i,
  input  logic        eip_i,
  input  logic        bip_i,
  input  logic        dslot_i,
  input  logic        imm_i,
  output entry_kind_e kind_o
);
  logic irq_open;

  assign irq_open = ie_i && !eip_i && !bip_i && !dslot_i && !imm_i;

  always_comb begin
    if (mmu_req_i)                      kind_o = KIND_MMU;
    else if (hw_req_i && cfg_exc_en_i)  kind_o = KIND_HWE;
    else if (brk_req_i)                 kind_o = KIND_BRK;
    else if (irq_req_i && irq_open)     kind_o = KIND_IRQ;
    else                                kind_o = KIND_NONE;
  end
endmodule

// File: rtl/exc_entry_ret.sv
module exc_entry_ret
  import exc_entry_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  entry_kind_e       kind_i,
  input  logic [DATA_W-1:0] pc_i,
  input  logic [DATA_W-1:0] vec_base_i,
  input  logic              dslot_i,
  input  logic              imm_i,
  input  logic              bimm_i,
  output logic [DATA_W-1:0] pc_o,
  output logic [4:0]        link_idx_o,
  output logic [DATA_W-1:0] link_val_o
);
  localparam logic [DATA_W-1:0] STEP1 = DATA_W'(4);
  localparam logic [DATA_W-1:0] STEP2 = DATA_W'(8);

  logic [DATA_W-1:0] mmu_ret;

  // fault return re-executes the branch or prefix that owns this instruction
  always_comb begin
    if (dslot_i)    mmu_ret = bimm_i ? pc_i - STEP2 : pc_i - STEP1;
    else if (imm_i) mmu_ret = pc_i - STEP1;
    else            mmu_ret = pc_i;
  end

  always_comb begin
    pc_o       = vec_base_i;
    link_idx_o = '0;
    link_val_o = pc_i;
    unique case (kind_i)
      KIND_MMU: begin
        pc_o       = vec_base_i + DATA_W'(OFF_EXC);
        link_idx_o = LINK_EXC;
        link_val_o = mmu_ret;
      end
      KIND_HWE: begin
        pc_o       = vec_base_i + DATA_W'(OFF_EXC);
        link_idx_o = LINK_EXC;
        link_val_o = pc_i + STEP1;
      end
      KIND_BRK: begin
        pc_o       = vec_base_i + DATA_W'(OFF_BRK);
        link_idx_o = LINK_BRK;
      end
      KIND_IRQ: begin
        pc_o       = vec_base_i + DATA_W'(OFF_IRQ);
        link_idx_o = LINK_IRQ;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/exc_entry_stat.sv
module exc_entry_stat
  import exc_entry_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned IE_BIT    = 1,
  parameter int unsigned BIP_BIT   = 3,
  parameter int unsigned EIP_BIT   = 9,
  parameter int unsigned UM_BIT    = 11,
  parameter int unsigned UMS_BIT   = 12,
  parameter int unsigned VM_BIT    = 13,
  parameter int unsigned VMS_BIT   = 14,
  parameter int unsigned DS_BIT    = 12,
  parameter int unsigned STORE_BIT = 10
) (
  input  entry_kind_e       kind_i,
  input  logic [DATA_W-1:0] msr_i,
  input  logic [DATA_W-1:0] hw_cause_i,
  input  logic              mmu_miss_i,
  input  logic [1:0]        mmu_acc_i,
  input  logic              dslot_i,
  output logic [DATA_W-1:0] msr_o,
  output logic [DATA_W-1:0] esr_o,
  output logic              esr_we_o
);
  localparam int unsigned MODE_N = 2;
  localparam int unsigned LIVE_POS [MODE_N] = '{UM_BIT, VM_BIT};
  localparam int unsigned SAVE_POS [MODE_N] = '{UMS_BIT, VMS_BIT};

  logic [DATA_W-1:0] mode_mask;
  logic [DATA_W-1:0] mode_save;
  logic [4:0]        mmu_code;

  for (genvar g = 0; g < MODE_N; g++) begin : g_mode
    logic [DATA_W-1:0] live_sel;
    logic [DATA_W-1:0] save_sel;
    assign live_sel = DATA_W'(1) << LIVE_POS[g];
    assign save_sel = DATA_W'(msr_i[LIVE_POS[g]]) << SAVE_POS[g];
  end

  always_comb begin
    mode_mask = '0;
    mode_save = '0;
    for (int i = 0; i < MODE_N; i++) begin
      mode_mask = mode_mask | (DATA_W'(1) << SAVE_POS[i]);
    end
    mode_mask = mode_mask | g_mode[0].live_sel | g_mode[1].live_sel;
    mode_save = g_mode[0].save_sel | g_mode[1].save_sel;
  end

  assign mmu_code = {3'b100, mmu_miss_i, mmu_acc_i == ACC_FETCH};

  always_comb begin
    msr_o    = (msr_i & ~mode_mask) | mode_save;
    esr_o    = '0;
    esr_we_o = 1'b0;
    unique case (kind_i)
      KIND_IRQ: msr_o[IE_BIT]  = 1'b0;
      KIND_BRK: msr_o[BIP_BIT] = 1'b1;
      KIND_MMU: begin
        msr_o[EIP_BIT]   = 1'b1;
        esr_o            = DATA_W'(mmu_code);
        esr_o[STORE_BIT] = mmu_acc_i == ACC_STORE;
        esr_o[DS_BIT]    = dslot_i;
        esr_we_o         = 1'b1;
      end
      KIND_HWE: begin
        msr_o[EIP_BIT] = 1'b1;
        esr_o          = hw_cause_i;
        esr_o[DS_BIT]  = dslot_i;
        esr_we_o       = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned IE_BIT    = 1,
  parameter int unsigned BIP_BIT   = 3,
  parameter int unsigned EIP_BIT   = 9,
  parameter int unsigned UM_BIT    = 11,
  parameter int unsigned UMS_BIT   = 12,
  parameter int unsigned VM_BIT    = 13,
  parameter int unsigned VMS_BIT   = 14,
  parameter int unsigned DS_BIT    = 12,
  parameter int unsigned STORE_BIT = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_exc_en_i,
  input  logic [DATA_W-1:0] vec_base_i,
  input  logic [DATA_W-1:0] pc_i,
  input  logic [DATA_W-1:0] msr_i,
  input  logic              dslot_i,
  input  logic              imm_i,
  input  logic              bimm_i,
  input  logic [DATA_W-1:0] btarget_i,
  input  logic [DATA_W-1:0] fault_addr_i,
  input  logic              hw_exc_req_i,
  input  logic [DATA_W-1:0] hw_exc_cause_i,
  input  logic              hw_exc_ear_i,
  input  logic              mmu_req_i,
  input  logic              mmu_miss_i,
  input  logic [1:0]        mmu_acc_i,
  input  logic              brk_req_i,
  input  logic              irq_req_i,
  output logic              entry_valid_o,
  output logic [DATA_W-1:0] pc_o,
  output logic              link_we_o,
  output logic [4:0]        link_idx_o,
  output logic [DATA_W-1:0] link_val_o,
  output logic [DATA_W-1:0] msr_o,
  output logic              esr_we_o,
  output logic [DATA_W-1:0] esr_o,
  output logic              ear_we_o,
  output logic [DATA_W-1:0] ear_o,
  output logic              btr_we_o,
  output logic [DATA_W-1:0] btr_o,
  output logic              resv_clr_o,
  output logic              iflags_clr_o
);
  entry_kind_e       kind;
  logic              take;
  logic              is_exc;
  logic [DATA_W-1:0] pc_n, link_val_n, msr_n, esr_n;
  logic [4:0]        link_idx_n;
  logic              esr_we_n, ear_we_n, btr_we_n;

  exc_entry_arb i_arb (
    .mmu_req_i   (mmu_req_i),
    .hw_req_i    (hw_exc_req_i),
    .cfg_exc_en_i(cfg_exc_en_i),
    .brk_req_i   (brk_req_i),
    .irq_req_i   (irq_req_i),
    .ie_i        (msr_i[IE_BIT]),
    .eip_i       (msr_i[EIP_BIT]),
    .bip_i       (msr_i[BIP_BIT]),
    .dslot_i     (dslot_i),
    .imm_i       (imm_i),
    .kind_o      (kind)
  );

  exc_entry_ret #(.DATA_W(DATA_W)) i_ret (
    .kind_i    (kind),
    .pc_i      (pc_i),
    .vec_base_i(vec_base_i),
    .dslot_i   (dslot_i),
    .imm_i     (imm_i),
    .bimm_i    (bimm_i),
    .pc_o      (pc_n),
    .link_idx_o(link_idx_n),
    .link_val_o(link_val_n)
  );

  exc_entry_stat #(
    .DATA_W(DATA_W), .IE_BIT(IE_BIT), .BIP_BIT(BIP_BIT), .EIP_BIT(EIP_BIT),
    .UM_BIT(UM_BIT), .UMS_BIT(UMS_BIT), .VM_BIT(VM_BIT), .VMS_BIT(VMS_BIT),
    .DS_BIT(DS_BIT), .STORE_BIT(STORE_BIT)
  ) i_stat (
    .kind_i    (kind),
    .msr_i     (msr_i),
    .hw_cause_i(hw_exc_cause_i),
    .mmu_miss_i(mmu_miss_i),
    .mmu_acc_i (mmu_acc_i),
    .dslot_i   (dslot_i),
    .msr_o     (msr_n),
    .esr_o     (esr_n),
    .esr_we_o  (esr_we_n)
  );

  assign take     = kind != KIND_NONE;
  assign is_exc   = kind == KIND_MMU || kind == KIND_HWE;
  assign btr_we_n = is_exc && dslot_i;
  assign ear_we_n = kind == KIND_MMU || (kind == KIND_HWE && hw_exc_ear_i);

  // pulses return low on every idle cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      entry_valid_o <= 1'b0;
      link_we_o     <= 1'b0;
      esr_we_o      <= 1'b0;
      ear_we_o      <= 1'b0;
      btr_we_o      <= 1'b0;
      resv_clr_o    <= 1'b0;
      iflags_clr_o  <= 1'b0;
    end else begin
      entry_valid_o <= take;
      link_we_o     <= take;
      esr_we_o      <= esr_we_n;
      ear_we_o      <= ear_we_n;
      btr_we_o      <= btr_we_n;
      resv_clr_o    <= take;
      iflags_clr_o  <= take;
    end
  end

  // data holds its last entry value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o       <= '0;
      link_idx_o <= '0;
      link_val_o <= '0;
      msr_o      <= '0;
      esr_o      <= '0;
      ear_o      <= '0;
      btr_o      <= '0;
    end else begin
      if (take) begin
        pc_o       <= pc_n;
        link_idx_o <= link_idx_n;
        link_val_o <= link_val_n;
        msr_o      <= msr_n;
      end
      if (esr_we_n) esr_o <= esr_n;
      if (ear_we_n) ear_o <= fault_addr_i;
      if (btr_we_n) btr_o <= btarget_i;
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned IE_BIT  = 1,
  parameter int unsigned BIP_BIT = 3,
  parameter int unsigned EIP_BIT = 9,
  parameter int unsigned UM_BIT  = 11,
  parameter int unsigned VM_BIT  = 13,
  parameter int unsigned DS_BIT  = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_exc_en_i,
  input logic [DATA_W-1:0] vec_base_i,
  input logic [DATA_W-1:0] msr_i,
  input logic              dslot_i,
  input logic              imm_i,
  input logic              hw_exc_req_i,
  input logic              mmu_req_i,
  input logic              brk_req_i,
  input logic              irq_req_i,
  input logic              entry_valid_o,
  input logic [DATA_W-1:0] pc_o,
  input logic              link_we_o,
  input logic [4:0]        link_idx_o,
  input logic [DATA_W-1:0] msr_o,
  input logic              esr_we_o,
  input logic [DATA_W-1:0] esr_o,
  input logic              btr_we_o,
  input logic              ear_we_o
);
  AST_IRQ_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_valid_o && link_idx_o == 5'd14 |-> pc_o == $past(vec_base_i) + DATA_W'(16)); // R1

  AST_EXC_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_valid_o && link_idx_o == 5'd17 |-> pc_o == $past(vec_base_i) + DATA_W'(32)); // R1

  AST_CAUSE_ONLY_EXC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    esr_we_o |-> link_we_o && link_idx_o == 5'd17); // R2

  AST_BTR_NEEDS_DS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    btr_we_o |-> esr_we_o && esr_o[DS_BIT]); // R5

  AST_LIVE_MODE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_valid_o |-> !msr_o[UM_BIT] && !msr_o[VM_BIT]); // R6

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_valid_o && link_idx_o == 5'd14 |->
      $past(msr_i[IE_BIT] && !msr_i[EIP_BIT] && !msr_i[BIP_BIT] && !dslot_i && !imm_i)); // R7

  AST_FAULT_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mmu_req_i) |-> entry_valid_o && link_idx_o == 5'd17 && ear_we_o); // R8

  AST_CFG_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(hw_exc_req_i && !cfg_exc_en_i && !mmu_req_i) |-> !esr_we_o); // R9

  AST_NO_REQ_NO_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!mmu_req_i && !hw_exc_req_i && !brk_req_i && !irq_req_i) |-> !entry_valid_o); // R11

  AST_EAR_NOT_ASYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ear_we_o |-> link_idx_o == 5'd17); // R10
endmodule

bind exc_entry_ctrl exc_entry_chk #(
  .DATA_W(DATA_W), .IE_BIT(IE_BIT), .BIP_BIT(BIP_BIT), .EIP_BIT(EIP_BIT),
  .UM_BIT(UM_BIT), .VM_BIT(VM_BIT), .DS_BIT(DS_BIT)
) i_exc_entry_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_exc_en_i (cfg_exc_en_i),
  .vec_base_i   (vec_base_i),
  .msr_i        (msr_i),
  .dslot_i      (dslot_i),
  .imm_i        (imm_i),
  .hw_exc_req_i (hw_exc_req_i),
  .mmu_req_i    (mmu_req_i),
  .brk_req_i    (brk_req_i),
  .irq_req_i    (irq_req_i),
  .entry_valid_o(entry_valid_o),
  .pc_o         (pc_o),
  .link_we_o    (link_we_o),
  .link_idx_o   (link_idx_o),
  .msr_o        (msr_o),
  .esr_we_o     (esr_we_o),
  .esr_o        (esr_o),
  .btr_we_o     (btr_we_o),
  .ear_we_o     (ear_we_o)
);

// File: tb/test_exc_entry_ctrl.sv
`timescale 1ns/1ps
module test_exc_entry_ctrl;
  localparam logic [31:0] PC    = 32'h0000_1000;
  localparam logic [31:0] BASE  = 32'h8000_0000;
  localparam logic [31:0] BTGT  = 32'h0000_2468;
  localparam logic [31:0] FADDR = 32'hDEAD_BEE0;

  typedef struct packed {
    logic [3:0]  req;   // {mmu, hw, brk, irq}
    logic        miss;
    logic [1:0]  acc;
    logic        ds;
    logic        im;
    logic        bim;
    logic [15:0] msr;
    logic        vld;
    logic [7:0]  off;
    logic [4:0]  idx;
    logic [7:0]  dlt;
    logic        esr_we;
    logic [15:0] esr;
    logic [15:0] msr_x;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VT [NV] = '{
    '{4'b0001,1'b0,2'd0,1'b0,1'b0,1'b0,16'h2802,1'b1,8'h10,5'd14,8'h00,1'b0,16'h0000,16'h5000},
    '{4'b0010,1'b0,2'd0,1'b0,1'b0,1'b0,16'h0800,1'b1,8'h18,5'd16,8'h00,1'b0,16'h0000,16'h1008},
    '{4'b0100,1'b0,2'd0,1'b0,1'b0,1'b0,16'h2000,1'b1,8'h20,5'd17,8'h04,1'b1,16'h0001,16'h4200},
    '{4'b0100,1'b0,2'd0,1'b1,1'b0,1'b0,16'h0000,1'b1,8'h20,5'd17,8'h04,1'b1,16'h1001,16'h0200},
    '{4'b1000,1'b0,2'd0,1'b0,1'b0,1'b0,16'h0000,1'b1,8'h20,5'd17,8'h00,1'b1,16'h0010,16'h0200},
    '{4'b1000,1'b0,2'd1,1'b0,1'b0,1'b0,16'h0000,1'b1,8'h20,5'd17,8'h00,1'b1,16'h0410,16'h0200},
    '{4'b1000,1'b0,2'd2,1'b0,1'b0,1'b0,16'h0000,1'b1,8'h20,5'd17,8'h00,1'b1,16'h0011,16'h0200},
    '{4'b1000,1'b1,2'd0,1'b0,1'b0,1'b0,16'h0000,1'b1,8'h20,5'd17,8'h00,1'b1,16'h0012,16'h0200},
    '{4'b1000,1'b1,2'd1,1'b0,1'b0,1'b0,16'h0000,1'b1,8'h20,5'd17,8'h00,1'b1,16'h0412,16'h0200},
    '{4'b1000,1'b1,2'd2,1'b0,1'b0,1'b0,16'h0000,1'b1,8'h20,5'd17,8'h00,1'b1,16'h0013,16'h0200},
    '{4'b1000,1'b0,2'd0,1'b1,1'b0,1'b1,16'h0000,1'b1,8'h20,5'd17,8'hF8,1'b1,16'h1010,16'h0200},
    '{4'b1000,1'b1,2'd2,1'b1,1'b0,1'b0,16'h0000,1'b1,8'h20,5'd17,8'hFC,1'b1,16'h1013,16'h0200},
    '{4'b1000,1'b0,2'd0,1'b0,1'b1,1'b0,16'h0000,1'b1,8'h20,5'd17,8'hFC,1'b1,16'h0010,16'h0200},
    '{4'b0001,1'b0,2'd0,1'b0,1'b0,1'b0,16'h0000,1'b0,8'h00,5'd0,8'h00,1'b0,16'h0000,16'h0000},
    '{4'b0001,1'b0,2'd0,1'b0,1'b0,1'b0,16'h0202,1'b0,8'h00,5'd0,8'h00,1'b0,16'h0000,16'h0000},
    '{4'b0001,1'b0,2'd0,1'b1,1'b0,1'b0,16'h0002,1'b0,8'h00,5'd0,8'h00,1'b0,16'h0000,16'h0000},
    '{4'b0001,1'b0,2'd0,1'b0,1'b1,1'b0,16'h0002,1'b0,8'h00,5'd0,8'h00,1'b0,16'h0000,16'h0000},
    '{4'b0001,1'b0,2'd0,1'b0,1'b0,1'b0,16'h000A,1'b0,8'h00,5'd0,8'h00,1'b0,16'h0000,16'h0000},
    '{4'b1111,1'b0,2'd0,1'b0,1'b0,1'b0,16'h0002,1'b1,8'h20,5'd17,8'h00,1'b1,16'h0010,16'h0202},
    '{4'b0111,1'b0,2'd0,1'b0,1'b0,1'b0,16'h0002,1'b1,8'h20,5'd17,8'h04,1'b1,16'h0001,16'h0202},
    '{4'b0011,1'b0,2'd0,1'b0,1'b0,1'b0,16'h0002,1'b1,8'h18,5'd16,8'h00,1'b0,16'h0000,16'h000A}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_en, ds, im, bim, hw_req, hw_ear, mmu_req, mmu_miss, brk_req, irq_req;
  logic [1:0]  acc;
  logic [31:0] msr;
  logic        entry_valid, link_we, esr_we, ear_we, btr_we, resv_clr, iflags_clr;
  logic [4:0]  link_idx;
  logic [31:0] pc_out, link_val, msr_out, esr_out, ear_out, btr_out;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;

  exc_entry_ctrl i_exc_entry_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cfg_exc_en_i(cfg_en), .vec_base_i(BASE),
    .pc_i(PC), .msr_i(msr), .dslot_i(ds), .imm_i(im), .bimm_i(bim),
    .btarget_i(BTGT), .fault_addr_i(FADDR), .hw_exc_req_i(hw_req),
    .hw_exc_cause_i(32'h0000_0001), .hw_exc_ear_i(hw_ear), .mmu_req_i(mmu_req),
    .mmu_miss_i(mmu_miss), .mmu_acc_i(acc), .brk_req_i(brk_req), .irq_req_i(irq_req),
    .entry_valid_o(entry_valid), .pc_o(pc_out), .link_we_o(link_we),
    .link_idx_o(link_idx), .link_val_o(link_val), .msr_o(msr_out),
    .esr_we_o(esr_we), .esr_o(esr_out), .ear_we_o(ear_we), .ear_o(ear_out),
    .btr_we_o(btr_we), .btr_o(btr_out), .resv_clr_o(resv_clr), .iflags_clr_o(iflags_clr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cfg_en = 1'b1; ds = 1'b0; im = 1'b0; bim = 1'b0; hw_req = 1'b0; hw_ear = 1'b0;
    mmu_req = 1'b0; mmu_miss = 1'b0; brk_req = 1'b0; irq_req = 1'b0;
    acc = 2'd0; msr = 32'h0;
  endtask

  // inputs set at a falling edge, result registered at the next rising edge
  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle();
    irq_req = 1'b1; brk_req = 1'b1; msr = 32'h2;
    repeat (3) @(negedge clk);
    chk("R12 entry_valid in reset", {31'b0, entry_valid}, 32'h0);
    chk("R12 write enables in reset", {27'b0, link_we, esr_we, ear_we, btr_we, resv_clr}, 32'h0);
    idle();
    rst_n = 1'b1;
    step();

    for (int i = 0; i < NV; i++) begin
      idle();
      {mmu_req, hw_req, brk_req, irq_req} = VT[i].req;
      mmu_miss = VT[i].miss; acc = VT[i].acc;
      ds = VT[i].ds; im = VT[i].im; bim = VT[i].bim;
      msr = {16'h0, VT[i].msr};
      step();
      chk($sformatf("R7 row %0d valid", i), {31'b0, entry_valid}, {31'b0, VT[i].vld});
      chk($sformatf("R11 row %0d link_we", i), {31'b0, link_we}, {31'b0, VT[i].vld});
      if (VT[i].vld) begin
        chk($sformatf("R1 row %0d pc", i), pc_out, BASE + {24'h0, VT[i].off});
        chk($sformatf("R2 row %0d link idx", i), {27'b0, link_idx}, {27'b0, VT[i].idx});
        chk($sformatf("R3 row %0d link value", i), link_val, PC + {{24{VT[i].dlt[7]}}, VT[i].dlt});
        chk($sformatf("R6 row %0d status", i), msr_out, {16'h0, VT[i].msr_x});
        chk($sformatf("R4 row %0d esr_we", i), {31'b0, esr_we}, {31'b0, VT[i].esr_we});
        if (VT[i].esr_we)
          chk($sformatf("R4 row %0d cause", i), esr_out, {16'h0, VT[i].esr});
      end
    end

    // R11: pulse lasts one cycle
    idle(); brk_req = 1'b1;
    step();
    chk("R11 reservation clear", {31'b0, resv_clr}, 32'h1);
    chk("R11 iflags clear", {31'b0, iflags_clr}, 32'h1);
    idle();
    step();
    chk("R11 valid drops", {31'b0, entry_valid}, 32'h0);
    chk("R11 reservation clear drops", {31'b0, resv_clr}, 32'h0);

    // R5: delay slot on exception loads BTR, outside it does not
    idle(); hw_req = 1'b1; ds = 1'b1;
    step();
    chk("R5 btr_we in delay slot", {31'b0, btr_we}, 32'h1);
    chk("R5 btr value", btr_out, BTGT);
    idle(); mmu_req = 1'b1;
    step();
    chk("R5 btr_we outside delay slot", {31'b0, btr_we}, 32'h0);
    chk("R5 ds bit cleared", {31'b0, esr_out[12]}, 32'h0);

    // R8: fault beats exception
    idle(); mmu_req = 1'b1; hw_req = 1'b1; mmu_miss = 1'b1;
    step();
    chk("R8 fault wins link value", link_val, PC);
    chk("R8 fault wins cause", esr_out, 32'h12);

    // R9: disabled exceptions are ignored
    idle(); cfg_en = 1'b0; hw_req = 1'b1; hw_ear = 1'b1;
    step();
    chk("R9 no entry", {31'b0, entry_valid}, 32'h0);
    chk("R9 no writes", {29'b0, esr_we, ear_we, link_we}, 32'h0);
    idle(); cfg_en = 1'b0; hw_req = 1'b1; brk_req = 1'b1;
    step();
    chk("R9 break still taken", {27'b0, link_idx}, 32'd16);
    chk("R9 no cause write", {31'b0, esr_we}, 32'h0);

    // R10: fault address capture
    idle(); mmu_req = 1'b1; acc = 2'd2;
    step();
    chk("R10 ear_we on fault", {31'b0, ear_we}, 32'h1);
    chk("R10 ear value", ear_out, FADDR);
    idle(); hw_req = 1'b1; hw_ear = 1'b0;
    step();
    chk("R10 no ear without flag", {31'b0, ear_we}, 32'h0);
    idle(); hw_req = 1'b1; hw_ear = 1'b1;
    step();
    chk("R10 ear with flag", {31'b0, ear_we}, 32'h1);
    idle(); irq_req = 1'b1; msr = 32'h2;
    step();
    chk("R10 no ear on interrupt", {31'b0, ear_we}, 32'h0);
    chk("R10 interrupt taken", {31'b0, entry_valid}, 32'h1);

    idle();
    step();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule